// File: doc/BRIEF.md
# Zero-Suppressing Hit-Record Derandomizer

This block sits between a sampled-comparator digitizer and a narrow output link. Every clock the digitizer presents a 64-bit amplitude word and a 16-bit coarse time. The block also receives a first-level activity flag. While that flag is low nothing is kept. When it rises, the block opens a record. The record holds the coarse time of that clock, then the amplitude word of the clock before the rise, then one amplitude word for each clock the flag stays high. Short single-photon hits and long waveform bursts therefore use one format and one storage path.

Records are written into a shared buffer one entry per clock. The coarse time fills one entry and each amplitude word fills one more. A record is made visible to the reader only once its last word is stored. If a record does not fit, it is discarded whole and a sticky flag reports the loss. The reader drains the buffer through a 4-bit port with a ready/valid handshake. This smooths out bursty hit arrivals. A marker bit tags the first nibble of every record.

Top module: `hitrec_derand`

## Requirements
- R1: While reset is high, and on the first clock after it, `nib_valid`, `nib_first` and `overflow` are low.
- R2: Activity-flag low periods store nothing, so no nibble appears at the output unless it belongs to a record.
- R3: A record opened by n consecutive clocks of `l0_act` high holds three parts, in this order. First, the coarse time sampled on the first high clock; the coarse time is ignored on the later high clocks. Second, the amplitude word presented one clock before the rise. Third, the amplitude words of each of the n high clocks. That gives n+1 words, and records leave in arrival order.
- R4: A record is sent as 4 coarse-time nibbles and then 16 nibbles per amplitude word, each field most significant nibble first.
- R5: `nib_first` is high exactly on the first coarse-time nibble of each record and low on every other nibble.
- R6: A nibble is consumed only on a clock with `nib_valid` and `nib_ready` both high. While `nib_valid` is high and `nib_ready` is low, `nib_data` and `nib_first` hold their values.
- R7: A record that does not fit in the free buffer space is dropped whole: none of its nibbles ever appear. `overflow` then goes high and stays high until reset. Later records that fit are stored normally.
- R8: The buffer holds 64 entries. A coarse time takes one entry and each amplitude word takes one. An entry is freed once it moves into the output stage. With the output stalled from an empty state, 21 single-clock records are all kept and the 22nd is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| l0_act | input | 1 | First-level activity flag |
| coarse_time | input | 16 | Coarse timestamp from the digitizer |
| amp_word | input | 64 | Amplitude and fine-time word for this clock |
| nib_ready | input | 1 | Downstream accepts a nibble |
| nib_data | output | 4 | Output nibble |
| nib_valid | output | 1 | `nib_data` holds a nibble |
| nib_first | output | 1 | Marks the first nibble of a record |
| overflow | output | 1 | Sticky flag: at least one record was dropped |

## Verification
The assertions assume that two activity periods are separated by at least two clocks with `l0_act` low. The writer needs those clocks to store the record's final word before the next coarse time arrives. The bench opens each record with one low clock that carries the leading word and closes it with three low clocks, so every gap is four clocks. The check that nothing is written during quiet periods relies on the same spacing. The drop test stalls the output completely, so the only entry that leaves the buffer is the single one taken by the output stage.

// File: rtl/zsd_pkg.sv
package zsd_pkg;
  // number of nibbles needed to carry a field of the given width
  function automatic int unsigned nib_count(input int unsigned bits, input int unsigned nib);
    return (bits + nib - 1) / nib;
  endfunction
endpackage

// File: rtl/zsd_capture.sv
// Turns the activity flag and the digitizer stream into one buffer entry per clock.
module zsd_capture #(
  parameter int CT_W  = 16,
  parameter int AMP_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             l0_act,
  input  logic [CT_W-1:0]  coarse_time,
  input  logic [AMP_W-1:0] amp_word,
  output logic             wr_req,
  output logic             wr_hdr,
  output logic             wr_last,
  output logic [AMP_W-1:0] wr_data
);
  localparam int PAD_W = AMP_W - CT_W;

  logic             act_d1, act_d2;
  logic [AMP_W-1:0] amp_d1, amp_d2;
  logic             opening, body;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_d1 <= 1'b0;
      act_d2 <= 1'b0;
      amp_d1 <= '0;
      amp_d2 <= '0;
    end else begin
      act_d1 <= l0_act;
      act_d2 <= act_d1;
      amp_d1 <= amp_word;
      amp_d2 <= amp_d1;
    end
  end

  // the coarse time goes in on the rising clock; the words trail two clocks behind,
  // starting with the word that preceded the rise
  assign opening = l0_act & ~act_d1;
  assign body    = act_d1 | act_d2;
  assign wr_req  = opening | body;
  assign wr_hdr  = opening;
  assign wr_last = body & ~act_d1;
  assign wr_data = opening ? {coarse_time, {PAD_W{1'b0}}} : amp_d2;
endmodule

// File: rtl/zsd_store.sv
// Circular entry buffer with speculative write pointer and whole-record commit.
module zsd_store #(
  parameter int W  = 64,
  parameter int AW = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_req,
  input  logic         wr_hdr,
  input  logic         wr_last,
  input  logic [W-1:0] wr_data,
  input  logic         rd_req,
  output logic         rd_avail,
  output logic         rd_hdr,
  output logic [W-1:0] rd_data,
  output logic         overflow
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;

  logic [W:0]    mem [DEPTH];
  logic [W:0]    rd_q;
  logic [PW-1:0] wtp, wcp, rp, used;
  logic          dropping, full, wr_go, drop_now, rd_fire, ovf_q;

  assign used     = wtp - rp;
  assign full     = (used == PW'(DEPTH));
  assign wr_go    = wr_req & ~dropping & ~full;
  assign drop_now = wr_req & ~dropping & full;
  assign rd_avail = (rp != wcp);
  assign rd_fire  = rd_req & rd_avail;

  always_ff @(posedge clk) begin
    if (rst) begin
      wtp      <= '0;
      wcp      <= '0;
      rp       <= '0;
      dropping <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      if (wr_go) wtp <= wtp + PW'(1);
      if (wr_go && wr_last) wcp <= wtp + PW'(1);
      if (drop_now) begin
        wtp   <= wcp;
        ovf_q <= 1'b1;
      end
      if (wr_req && wr_last) dropping <= 1'b0;
      else if (drop_now) dropping <= 1'b1;
      if (rd_fire) rp <= rp + PW'(1);
    end
  end

  // storage without reset so that a block RAM can be inferred
  always_ff @(posedge clk) begin
    if (wr_go) mem[wtp[AW-1:0]] <= {wr_hdr, wr_data};
    if (rd_fire) rd_q <= mem[rp[AW-1:0]];
  end

  assign rd_hdr   = rd_q[W];
  assign rd_data  = rd_q[W-1:0];
  assign overflow = ovf_q;
endmodule

// File: rtl/zsd_nibout.sv
// Fetches one entry at a time and shifts it out a nibble per accepted clock.
module zsd_nibout #(
  parameter int W     = 64,
  parameter int CT_W  = 16,
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_avail,
  output logic             rd_req,
  input  logic             rd_hdr,
  input  logic [W-1:0]     rd_data,
  input  logic             nib_ready,
  output logic [NIB_W-1:0] nib_data,
  output logic             nib_valid,
  output logic             nib_first
);
  localparam int unsigned HDR_N = zsd_pkg::nib_count(CT_W, NIB_W);
  localparam int unsigned DAT_N = zsd_pkg::nib_count(W, NIB_W);
  localparam int CW = $clog2(DAT_N + 1);

  logic          pend, bfirst, adv, have;
  logic [W-1:0]  shreg;
  logic [CW-1:0] cnt;

  assign have   = (cnt != '0);
  assign adv    = ~nib_valid | nib_ready;
  assign rd_req = rd_avail & ~pend & ~have;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend      <= 1'b0;
      bfirst    <= 1'b0;
      cnt       <= '0;
      shreg     <= '0;
      nib_valid <= 1'b0;
      nib_first <= 1'b0;
      nib_data  <= '0;
    end else begin
      pend <= rd_req;
      if (pend) begin
        shreg  <= rd_data;
        cnt    <= rd_hdr ? CW'(HDR_N) : CW'(DAT_N);
        bfirst <= rd_hdr;
      end else if (adv && have) begin
        shreg  <= shreg << NIB_W;
        cnt    <= cnt - CW'(1);
        bfirst <= 1'b0;
      end
      if (adv) begin
        nib_valid <= have;
        nib_first <= bfirst & have;
        nib_data  <= shreg[W-1 -: NIB_W];
      end
    end
  end
endmodule

// File: rtl/hitrec_derand.sv
module hitrec_derand #(
  parameter int CT_W  = 16,
  parameter int AMP_W = 64,
  parameter int NIB_W = 4,
  parameter int AW    = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             l0_act,
  input  logic [CT_W-1:0]  coarse_time,
  input  logic [AMP_W-1:0] amp_word,
  input  logic             nib_ready,
  output logic [NIB_W-1:0] nib_data,
  output logic             nib_valid,
  output logic             nib_first,
  output logic             overflow
);
  logic             cap_wr, cap_hdr, cap_last;
  logic [AMP_W-1:0] cap_data;
  logic             rd_avail, rd_req, rd_hdr;
  logic [AMP_W-1:0] rd_data;

  zsd_capture #(.CT_W(CT_W), .AMP_W(AMP_W)) u_cap (
    .clk(clk), .rst(rst), .l0_act(l0_act), .coarse_time(coarse_time),
    .amp_word(amp_word), .wr_req(cap_wr), .wr_hdr(cap_hdr),
    .wr_last(cap_last), .wr_data(cap_data)
  );

  zsd_store #(.W(AMP_W), .AW(AW)) u_store (
    .clk(clk), .rst(rst), .wr_req(cap_wr), .wr_hdr(cap_hdr),
    .wr_last(cap_last), .wr_data(cap_data), .rd_req(rd_req),
    .rd_avail(rd_avail), .rd_hdr(rd_hdr), .rd_data(rd_data),
    .overflow(overflow)
  );

  zsd_nibout #(.W(AMP_W), .CT_W(CT_W), .NIB_W(NIB_W)) u_out (
    .clk(clk), .rst(rst), .rd_avail(rd_avail), .rd_req(rd_req),
    .rd_hdr(rd_hdr), .rd_data(rd_data), .nib_ready(nib_ready),
    .nib_data(nib_data), .nib_valid(nib_valid), .nib_first(nib_first)
  );
endmodule

// File: rtl/zsd_checker.sv
module zsd_checker #(
  parameter int NIB_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             l0_act,
  input logic             cap_wr,
  input logic             nib_valid,
  input logic             nib_ready,
  input logic             nib_first,
  input logic [NIB_W-1:0] nib_data,
  input logic             overflow
);
  logic h1, h2;
  always_ff @(posedge clk) begin
    if (rst) begin
      h1 <= 1'b0;
      h2 <= 1'b0;
    end else begin
      h1 <= l0_act;
      h2 <= h1;
    end
  end

  p_reset_r1: assert property (@(posedge clk) rst |=> (!nib_valid && !nib_first && !overflow));

  p_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (!l0_act && !h1 && !h2) |-> !cap_wr);

  p_first_valid_r5: assert property (@(posedge clk) disable iff (rst)
    nib_first |-> nib_valid);

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (nib_valid && !nib_ready) |=> (nib_valid && $stable(nib_data) && $stable(nib_first)));

  p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);
endmodule

bind hitrec_derand zsd_checker #(.NIB_W(NIB_W)) u_chk (
  .clk(clk), .rst(rst), .l0_act(l0_act), .cap_wr(cap_wr),
  .nib_valid(nib_valid), .nib_ready(nib_ready), .nib_first(nib_first),
  .nib_data(nib_data), .overflow(overflow)
);

// File: tb/sim_hitrec_derand.sv
module sim_hitrec_derand;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        l0_act = 1'b0;
  logic [15:0] coarse_time = '0;
  logic [63:0] amp_word = '0;
  logic        nib_ready = 1'b1;
  logic [3:0]  nib_data;
  logic        nib_valid, nib_first, overflow;

  int checks = 0;
  int errors = 0;
  int wcnt = 1;
  int rmode = 0;
  int nfirst = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [4:0] q[$];

  always #5 clk = ~clk;

  hitrec_derand u0 (
    .clk(clk), .rst(rst), .l0_act(l0_act), .coarse_time(coarse_time),
    .amp_word(amp_word), .nib_ready(nib_ready), .nib_data(nib_data),
    .nib_valid(nib_valid), .nib_first(nib_first), .overflow(overflow)
  );

  function automatic logic [63:0] mkword(input int k);
    logic [31:0] a;
    a = k * 32'h9E3779B1 + 32'h01234567;
    return {a, ~a ^ 32'h0F0F0F0F};
  endfunction

  task automatic push_word(input logic [63:0] w);
    for (int j = 0; j < 16; j++) q.push_back({1'b0, w[63-4*j -: 4]});
  endtask

  task automatic push_ct(input logic [15:0] ct);
    for (int j = 0; j < 4; j++) q.push_back({(j == 0), ct[15-4*j -: 4]});
  endtask

  // one low clock carrying the leading word, n high clocks, three low clocks
  task automatic send_rec(input int n, input logic [15:0] ct, input bit keep);
    logic [63:0] w;
    @(negedge clk);
    l0_act = 1'b0;
    w = mkword(wcnt); wcnt++;
    amp_word = w;
    if (keep) begin push_ct(ct); push_word(w); end
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      l0_act = 1'b1;
      coarse_time = (i == 0) ? ct : ~ct;   // R3: only the first high clock counts
      w = mkword(wcnt); wcnt++;
      amp_word = w;
      if (keep) push_word(w);
    end
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      l0_act = 1'b0;
      amp_word = mkword(wcnt); wcnt++;
      coarse_time = coarse_time + 16'h0101;
    end
  endtask

  task automatic wait_drain();
    while (q.size() != 0) @(negedge clk);
    repeat (12) @(negedge clk);
  endtask

  task automatic check1(input bit ok, input string req, input string what,
                        input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ready generator, changes away from both edges
  initial begin
    forever begin
      @(posedge clk);
      #2;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (rmode)
        0: nib_ready = 1'b1;
        1: nib_ready = lfsr[0] | lfsr[3];
        default: nib_ready = 1'b0;
      endcase
    end
  end

  // monitor / scoreboard
  logic       stall_prev = 1'b0;
  logic [3:0] stall_data = '0;
  logic       stall_first = 1'b0;
  initial begin
    logic [4:0] e;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (stall_prev) begin
          check1(nib_valid && nib_data == stall_data && nib_first == stall_first,
                 "R6", "held nibble changed", int'(nib_data), int'(stall_data));
        end
        if (nib_valid && nib_ready) begin
          if (q.size() == 0) begin
            check1(1'b0, "R2", "unexpected nibble", int'(nib_data), -1);
          end else begin
            e = q.pop_front();
            check1(nib_data == e[3:0], "R4", "nibble value", int'(nib_data), int'(e[3:0]));
            check1(nib_first == e[4], "R5", "marker", int'(nib_first), int'(e[4]));
            if (nib_first) nfirst++;
          end
        end
        stall_prev  = nib_valid && !nib_ready;
        stall_data  = nib_data;
        stall_first = nib_first;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R3 watchdog: pending nibbles %0d expected 0", q.size());
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    check1(!nib_valid && !nib_first && !overflow, "R1", "reset outputs",
           int'({nib_valid, nib_first, overflow}), 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check1(!nib_valid && !overflow, "R1", "after reset", int'({nib_valid, overflow}), 0);

    // R2: quiet period with changing data
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      amp_word = mkword(1000 + i);
      coarse_time = 16'(i * 77);
    end
    repeat (5) @(negedge clk);
    check1(!nib_valid, "R2", "output during quiet period", int'(nib_valid), 0);

    // single hits, output always ready
    rmode = 0;
    send_rec(1, 16'h1A2B, 1'b1);
    send_rec(1, 16'hF00D, 1'b1);
    send_rec(1, 16'h0001, 1'b1);
    wait_drain();
    check1(q.size() == 0, "R3", "single hits drained", q.size(), 0);

    // mixed lengths and a waveform under random backpressure
    rmode = 1;
    send_rec(1, 16'h4321, 1'b1);
    send_rec(2, 16'h8000, 1'b1);
    send_rec(5, 16'hBEEF, 1'b1);
    wait_drain();
    send_rec(40, 16'h7E57, 1'b1);
    wait_drain();
    check1(q.size() == 0, "R3", "waveform drained", q.size(), 0);
    check1(!overflow, "R7", "flag without loss", int'(overflow), 0);

    // capacity and drop with the output stalled
    rmode = 2;
    repeat (4) @(negedge clk);
    base = nfirst;
    for (int i = 0; i < 22; i++) send_rec(1, 16'(16'h2000 + i), (i < 21));
    repeat (4) @(negedge clk);
    check1(overflow, "R7", "flag after dropped record", int'(overflow), 1);
    rmode = 0;
    wait_drain();
    check1(nfirst - base == 21, "R8", "records kept while stalled", nfirst - base, 21);

    // storage keeps working after a drop; flag stays
    rmode = 1;
    send_rec(3, 16'hC0DE, 1'b1);
    wait_drain();
    check1(q.size() == 0, "R7", "record after drop", q.size(), 0);
    check1(overflow, "R7", "flag sticky", int'(overflow), 1);
    check1(!nib_valid, "R2", "idle at end", int'(nib_valid), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule